// File: doc/BRIEF.md
# Triggered Dual Delay Pulse Generator

This block waits for a rising edge on one selectable trigger line and then runs a 16-bit counter. The counter advances once every 2^prescale clocks. Two delay channels each hold a programmed 16-bit match value. Each channel emits a single-clock pulse when the running count reaches that value, so one trigger can schedule two events at independent offsets.

A combined level output turns on at the channel 0 match and off at the channel 1 match. Software therefore sets both edges of one pulse. A period ends when the count reaches the programmed modulus. In one-shot mode the counter then stops and waits for the next trigger. In continuous mode it starts again from zero.

A bypass setting sends the selected trigger straight to the outputs without the counter. A trigger edge that arrives while a run is in progress is dropped and reported on an error strobe. All settings arrive on plain parallel configuration inputs. They are expected to stay stable while a run is in progress.

Top module: `trig_delay_pulse`

## Requirements
- R1: After reset, `busy`, `dly_pulse`, `pulse_out` and `seq_err` are all low. While bypass is off, a rising edge on the selected trigger line (`trig_in[cfg_trig_sel]`, low on one sampling clock edge and high on the next) starts a run with the count at zero, and `busy` goes high in the cycle after that edge.
- R2: Holding the selected trigger line high, dropping it, or toggling a line that is not selected never starts a run. A line that is already high when reset is released needs a low first.
- R3: Take E as the clock edge that samples the trigger rise. An enabled channel k whose delay is D pulses `dly_pulse[k]` in the cycle after edge E + 1 + D·2^P, where P is `cfg_prescale`.
- R4: With a nonzero modulus, each channel match produces a pulse exactly one clock wide.
- R5: The count advances once every 2^P clocks, for P from 0 to 7.
- R6: `pulse_out` rises in the cycle where channel 0 pulses and falls in the cycle where channel 1 pulses. If both pulse together, low wins.
- R7: In one-shot mode (`cfg_continuous`=0) a run lasts (modulus+1)·2^P clocks. `busy` then falls and no further pulses occur until a new trigger.
- R8: In continuous mode the count wraps to zero after the modulus value and the channel pulses repeat every (modulus+1)·2^P clocks without a new trigger.
- R9: A channel whose bit in `cfg_ch_en` is 0 never pulses, in bypass mode as well.
- R10: With `cfg_bypass`=1, `dly_pulse` equals the selected trigger ANDed with `cfg_ch_en`, `pulse_out` equals the selected trigger in the same cycle, and no run starts.
- R11: A trigger edge during a run does not restart the count: channel timing is unchanged, and `seq_err` is high for the one cycle after that edge.
- R12: A channel whose delay exceeds the modulus never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | N_TRIG | Candidate trigger lines |
| cfg_trig_sel | input | SEL_W | Index of the trigger line in use |
| cfg_prescale | input | PRE_W | Count step is 2^value clocks |
| cfg_modulus | input | CNT_W | Last count value of a period |
| cfg_delay0 | input | CNT_W | Match value of channel 0 |
| cfg_delay1 | input | CNT_W | Match value of channel 1 |
| cfg_ch_en | input | 2 | Per-channel enable |
| cfg_continuous | input | 1 | 1 = restart after each period |
| cfg_bypass | input | 1 | 1 = trigger passes straight through |
| dly_pulse | output | 2 | Delayed single-clock pulses |
| pulse_out | output | 1 | Level set by channel 0, cleared by channel 1 |
| busy | output | 1 | Run in progress |
| seq_err | output | 1 | Strobe for a trigger dropped during a run |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 3-bit prescale selector and two trigger lines. With two lines, an edge on the unused line can be shown to have no effect. Small modulus and delay values keep each period within a few dozen clocks, and a prescale of 2 shows the step stretching without long runs. This makes it possible to cover one-shot completion, continuous wrap, clear-wins ordering, out-of-range delays and retrigger rejection in one short run.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    localparam int TDP_CNT_W  = 16;
    localparam int TDP_PRE_W  = 3;
    localparam int TDP_NTRIG  = 2;
    localparam int TDP_NCH    = 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // width of a divider counter able to reach 2^(2^pw - 1) - 1
    function automatic int div_cnt_w(int pw);
        return (1 << pw) - 1;
    endfunction

    function automatic int sel_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdp_edge.sv
module tdp_edge #(
    parameter int N_TRIG = tdp_pkg::TDP_NTRIG,
    localparam int SEL_W = tdp_pkg::sel_w(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              level,
    output logic              rise
);
    logic prev_q;

    assign level = trig_in[sel];
    assign rise  = level & ~prev_q;

    // resets high so a line already high at reset release is not an edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level;
    end
endmodule

// File: rtl/tdp_sequencer.sv
module tdp_sequencer
    import tdp_pkg::*;
#(
    parameter int CNT_W = TDP_CNT_W,
    parameter int PRE_W = TDP_PRE_W,
    localparam int PCW  = div_cnt_w(PRE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             bypass,
    input  logic             continuous,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] modulus,
    output logic             busy,
    output logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             seq_err
);
    localparam logic [PCW-1:0] ALL1 = '1;

    seq_state_e       st_q;
    logic [PCW-1:0]   pre_q;
    logic [PCW-1:0]   pre_last;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             wrap_tick;

    assign pre_last  = ALL1 >> (PCW - int'(prescale));
    assign wrap_tick = (pre_q == pre_last);
    assign busy      = (st_q == SEQ_RUN);
    assign step      = busy && (pre_q == '0);
    assign cnt       = cnt_q;
    assign seq_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            pre_q <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= busy && rise && !bypass;
            case (st_q)
                SEQ_IDLE: begin
                    pre_q <= '0;
                    cnt_q <= '0;
                    if (rise && !bypass) st_q <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    pre_q <= wrap_tick ? '0 : pre_q + 1'b1;
                    if (wrap_tick) begin
                        if (cnt_q == modulus) begin
                            cnt_q <= '0;
                            if (!continuous) st_q <= SEQ_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tdp_channel.sv
module tdp_channel #(
    parameter int CNT_W = tdp_pkg::TDP_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] delay,
    input  logic             en,
    output logic             fire,
    output logic             pulse_q
);
    assign fire = step && en && (cnt == delay);

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= fire;
    end
endmodule

// File: rtl/trig_delay_pulse.sv
module trig_delay_pulse
    import tdp_pkg::*;
#(
    parameter int CNT_W  = TDP_CNT_W,
    parameter int PRE_W  = TDP_PRE_W,
    parameter int N_TRIG = TDP_NTRIG,
    localparam int SEL_W = sel_w(N_TRIG),
    localparam int NCH   = TDP_NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  cfg_trig_sel,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [CNT_W-1:0]  cfg_modulus,
    input  logic [CNT_W-1:0]  cfg_delay0,
    input  logic [CNT_W-1:0]  cfg_delay1,
    input  logic [NCH-1:0]    cfg_ch_en,
    input  logic              cfg_continuous,
    input  logic              cfg_bypass,
    output logic [NCH-1:0]    dly_pulse,
    output logic              pulse_out,
    output logic              busy,
    output logic              seq_err
);
    logic             tsel, rise, step;
    logic [CNT_W-1:0] cnt_q;
    logic [NCH-1:0]   fire, dly_q;
    logic [CNT_W-1:0] delay_v [NCH];
    logic             lvl_q;

    assign delay_v[0] = cfg_delay0;
    assign delay_v[1] = cfg_delay1;

    tdp_edge #(.N_TRIG(N_TRIG)) u_edge (
        .clk(clk), .rst(rst), .trig_in(trig_in), .sel(cfg_trig_sel),
        .level(tsel), .rise(rise)
    );

    tdp_sequencer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_seq (
        .clk(clk), .rst(rst), .rise(rise), .bypass(cfg_bypass),
        .continuous(cfg_continuous), .prescale(cfg_prescale),
        .modulus(cfg_modulus), .busy(busy), .step(step), .cnt(cnt_q),
        .seq_err(seq_err)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        tdp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .step(step), .cnt(cnt_q),
            .delay(delay_v[k]), .en(cfg_ch_en[k]),
            .fire(fire[k]), .pulse_q(dly_q[k])
        );
    end

    // channel 1 (falling edge) wins over channel 0
    always_ff @(posedge clk) begin
        if (rst)          lvl_q <= 1'b0;
        else if (fire[1]) lvl_q <= 1'b0;
        else if (fire[0]) lvl_q <= 1'b1;
    end

    assign dly_pulse = cfg_bypass ? ({NCH{tsel}} & cfg_ch_en) : dly_q;
    assign pulse_out = cfg_bypass ? tsel : lvl_q;
endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
    parameter int CNT_W  = 16,
    parameter int N_TRIG = 2,
    parameter int SEL_W  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [N_TRIG-1:0] trig_in,
    input logic [SEL_W-1:0]  cfg_trig_sel,
    input logic [CNT_W-1:0]  cfg_modulus,
    input logic [1:0]        cfg_ch_en,
    input logic              cfg_continuous,
    input logic              cfg_bypass,
    input logic [1:0]        dly_pulse,
    input logic              pulse_out,
    input logic              busy,
    input logic              seq_err,
    input logic [CNT_W-1:0]  cnt
);
    logic tsel;
    assign tsel = trig_in[cfg_trig_sel];

    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(tsel, 1) && !$past(tsel, 2))); // R2

    AST_CH0_GATED: assert property (@(posedge clk) disable iff (rst)
        !cfg_ch_en[0] |-> !dly_pulse[0]); // R9

    AST_CH1_GATED: assert property (@(posedge clk) disable iff (rst)
        !cfg_ch_en[1] |-> !dly_pulse[1]); // R9

    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && dly_pulse[1]) |-> !pulse_out); // R6

    AST_ERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> $past(busy)); // R11

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(cfg_continuous)); // R7

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= cfg_modulus)); // R8

    AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cfg_bypass && !busy) |=> !busy); // R10
endmodule

bind trig_delay_pulse tdp_checker #(
    .CNT_W(CNT_W), .N_TRIG(N_TRIG), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_trig_sel(cfg_trig_sel),
    .cfg_modulus(cfg_modulus), .cfg_ch_en(cfg_ch_en),
    .cfg_continuous(cfg_continuous), .cfg_bypass(cfg_bypass),
    .dly_pulse(dly_pulse), .pulse_out(pulse_out), .busy(busy),
    .seq_err(seq_err), .cnt(cnt_q)
);

// File: tb/sim_trig_delay_pulse.sv
module sim_trig_delay_pulse;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  trig_in = '0;
    logic [0:0]  cfg_trig_sel = '0;
    logic [2:0]  cfg_prescale = '0;
    logic [15:0] cfg_modulus = 16'd20;
    logic [15:0] cfg_delay0 = '0;
    logic [15:0] cfg_delay1 = '0;
    logic [1:0]  cfg_ch_en = 2'b11;
    logic        cfg_continuous = 1'b0;
    logic        cfg_bypass = 1'b0;
    logic [1:0]  dly_pulse;
    logic        pulse_out, busy, seq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_delay_pulse u0 (
        .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_trig_sel(cfg_trig_sel),
        .cfg_prescale(cfg_prescale), .cfg_modulus(cfg_modulus),
        .cfg_delay0(cfg_delay0), .cfg_delay1(cfg_delay1),
        .cfg_ch_en(cfg_ch_en), .cfg_continuous(cfg_continuous),
        .cfg_bypass(cfg_bypass), .dly_pulse(dly_pulse),
        .pulse_out(pulse_out), .busy(busy), .seq_err(seq_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // launch on trig_in[line], then watch win cycles (sample i follows edge E+i)
    task automatic run_win(input int line, input bit raise, input int win,
                           input int drop_at, input int rise_at,
                           output int f0, output int f1, output int l0,
                           output int w0, output int p0, output int p1,
                           output int se, output int bz);
        f0 = -1; f1 = -1; l0 = -1; w0 = 0; p0 = -1; p1 = -1; se = 0; bz = 0;
        @(negedge clk);
        if (raise) trig_in[line] = 1'b1;
        for (int i = 0; i < win; i++) begin
            @(posedge clk); #1;
            if (dly_pulse[0]) begin
                w0++; l0 = i;
                if (f0 < 0) begin f0 = i; p0 = int'(pulse_out); end
            end
            if (dly_pulse[1] && f1 < 0) begin f1 = i; p1 = int'(pulse_out); end
            if (seq_err) se++;
            bz = int'(busy);
            if (i == drop_at) trig_in[line] = 1'b0;
            if (i == rise_at) trig_in[line] = 1'b1;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && dly_pulse == 2'b00 && !pulse_out && !seq_err, "R1 idle after reset",
            int'({busy, dly_pulse, pulse_out, seq_err}), 0);
    endtask

    task automatic t_basic();
        int f0, f1, l0, w0, p0, p1, se, bz;
        cfg_prescale = 3'd0; cfg_modulus = 16'd20; cfg_delay0 = 16'd3; cfg_delay1 = 16'd7;
        run_win(0, 1, 30, 1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f0 == 4, "R3 ch0 timing", f0, 4);
        chk(f1 == 8, "R3 ch1 timing", f1, 8);
        chk(w0 == 1, "R4 one-clock pulse", w0, 1);
        chk(p0 == 1, "R6 rise at ch0", p0, 1);
        chk(p1 == 0, "R6 fall at ch1", p1, 0);
        chk(bz == 0, "R7 one-shot ends", bz, 0);
    endtask

    task automatic t_prescale();
        int f0, f1, l0, w0, p0, p1, se, bz;
        cfg_prescale = 3'd2; cfg_modulus = 16'd20; cfg_delay0 = 16'd2; cfg_delay1 = 16'd5;
        run_win(0, 1, 30, 1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f0 == 9, "R5 ch0 scaled", f0, 9);
        chk(f1 == 21, "R5 ch1 scaled", f1, 21);
        repeat (70) @(posedge clk);
        #1 chk(!busy, "R7 scaled run ends", int'(busy), 0);
        cfg_prescale = 3'd0;
    endtask

    task automatic t_edge_only();
        int f0, f1, l0, w0, p0, p1, se, bz;
        cfg_modulus = 16'd20; cfg_delay0 = 16'd3; cfg_delay1 = 16'd7;
        run_win(1, 1, 20, 5, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f0 < 0 && bz == 0, "R2 unselected line", f0, -1);
        run_win(0, 1, 30, -1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f0 == 4, "R1 launch", f0, 4);
        run_win(0, 0, 30, -1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f0 < 0 && bz == 0, "R2 held level", f0, -1);
        run_win(0, 0, 20, 0, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f0 < 0 && bz == 0, "R2 falling edge", f0, -1);
    endtask

    task automatic t_enable_and_order();
        int f0, f1, l0, w0, p0, p1, se, bz;
        cfg_ch_en = 2'b01; cfg_delay0 = 16'd3; cfg_delay1 = 16'd7;
        run_win(0, 1, 30, 1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f1 < 0, "R9 ch1 disabled", f1, -1);
        chk(pulse_out == 1'b1, "R6 level held", int'(pulse_out), 1);
        cfg_ch_en = 2'b11; cfg_delay0 = 16'd5; cfg_delay1 = 16'd5;
        run_win(0, 1, 30, 1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f1 == 6 && p1 == 0, "R6 clear wins", p1, 0);
    endtask

    task automatic t_out_of_range();
        int f0, f1, l0, w0, p0, p1, se, bz;
        cfg_modulus = 16'd10; cfg_delay0 = 16'd2; cfg_delay1 = 16'd15;
        run_win(0, 1, 30, 1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(f0 == 3, "R12 in-range ch0", f0, 3);
        chk(f1 < 0, "R12 beyond modulus", f1, -1);
    endtask

    task automatic t_continuous();
        int f0, f1, l0, w0, p0, p1, se, bz;
        cfg_modulus = 16'd9; cfg_delay0 = 16'd2; cfg_delay1 = 16'd6; cfg_continuous = 1'b1;
        run_win(0, 1, 25, 1, -1, f0, f1, l0, w0, p0, p1, se, bz);
        chk(w0 == 3, "R8 repeat count", w0, 3);
        chk(l0 == 23, "R8 period", l0, 23);
        chk(bz == 1, "R8 still busy", bz, 1);
        cfg_continuous = 1'b0;
        repeat (12) @(posedge clk);
        #1 chk(!busy, "R7 stops after period", int'(busy), 0);
    endtask

    task automatic t_retrigger();
        int f0, f1, l0, w0, p0, p1, se, bz;
        cfg_modulus = 16'd20; cfg_delay0 = 16'd10; cfg_delay1 = 16'd12;
        run_win(0, 1, 30, 1, 3, f0, f1, l0, w0, p0, p1, se, bz);
        chk(se == 1, "R11 error strobe", se, 1);
        chk(f0 == 11, "R11 timing kept", f0, 11);
        trig_in[0] = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic t_bypass();
        cfg_bypass = 1'b1; cfg_ch_en = 2'b11;
        @(negedge clk); trig_in[0] = 1'b1; #1;
        chk(dly_pulse == 2'b11 && pulse_out, "R10 pass through",
            int'({dly_pulse, pulse_out}), 7);
        cfg_ch_en = 2'b01; #1;
        chk(dly_pulse == 2'b01, "R9 gated in bypass", int'(dly_pulse), 1);
        repeat (3) @(posedge clk);
        #1 chk(!busy, "R10 no run", int'(busy), 0);
        @(negedge clk); trig_in[0] = 1'b0; #1;
        chk(dly_pulse == 2'b00 && !pulse_out, "R10 follows low",
            int'({dly_pulse, pulse_out}), 0);
        cfg_bypass = 1'b0; cfg_ch_en = 2'b11;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic();
        t_prescale();
        t_edge_only();
        t_enable_and_order();
        t_out_of_range();
        t_continuous();
        t_retrigger();
        t_bypass();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WDOG_CYC && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule